// File: doc/BRIEF.md
# Sixteen-Opcode Data-Processing ALU

This block executes the sixteen classic integer data-processing operations of a load/store processor core: bitwise logic, move and inverted move, add, subtract and subtract in reverse operand order, the carry-chained forms of those arithmetic operations, and four test/compare operations. The second operand arrives already shifted or rotated, together with the carry produced by that shifter. The register form and the immediate form of an instruction use the same opcode. Condition evaluation happens elsewhere in the core.

The caller presents an opcode, both operands, the current NZCV flags, the shifter carry and a set-flags request, and raises `op_valid` for one cycle. One clock edge later the block presents the result and a destination write strobe. It also presents the next NZCV value, with a strobe that says whether the flag register should take that value. All outputs are registered.

Top module: `dp_alu`

## Requirements
- R1: Logical opcodes give res = rn AND op2 (0x0, 0x8), rn XOR op2 (0x1, 0x9), rn OR op2 (0xC), op2 (0xD), rn AND NOT op2 (0xE) and NOT op2 (0xF).
- R2: Arithmetic opcodes give res = rn - op2 (0x2, 0xA), op2 - rn (0x3), rn + op2 (0x4, 0xB), all modulo 2^32.
- R3: Carry-chained opcodes use the incoming C flag (nzcv_in[1]): 0x5 gives rn + op2 + C, 0x6 gives rn - op2 - (1-C), 0x7 gives op2 - rn - (1-C).
- R4: Opcodes 0x8 to 0xB never raise res_we; every other accepted opcode raises res_we.
- R5: Outputs appear exactly one clock edge after an op_valid cycle: out_valid is high in the following cycle only.
- R6: On a flag update, N (nzcv_out[3]) is bit 31 of res and Z (nzcv_out[2]) is 1 exactly when res is zero.
- R7: For arithmetic opcodes an updated C is the carry out of the addition; for subtract-type opcodes this means C = 1 when no borrow occurs.
- R8: For arithmetic opcodes an updated V (nzcv_out[0]) is 1 exactly on two's-complement overflow of the operation in its actual operand order.
- R9: For logical opcodes an updated C equals shift_cout and V keeps nzcv_in[0].
- R10: flags_we is high and nzcv_out carries new flags when set_flags is high or the opcode is 0x8 to 0xB; otherwise flags_we is low and nzcv_out equals nzcv_in.
- R11: While rst_n is low, out_valid, res_we, flags_we, res and nzcv_out are all zero.
- R12: A cycle with op_valid low gives out_valid, res_we and flags_we low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Data-processing opcode |
| rn | input | 32 | First operand |
| op2 | input | 32 | Second operand, already shifted |
| nzcv_in | input | 4 | Current flags {N,Z,C,V} |
| shift_cout | input | 1 | Carry out of the operand shifter |
| set_flags | input | 1 | Request a flag update |
| out_valid | output | 1 | Registered result present |
| res | output | 32 | Registered result |
| res_we | output | 1 | Write res to the destination register |
| nzcv_out | output | 4 | Next flag value {N,Z,C,V} |
| flags_we | output | 1 | Load nzcv_out into the flag register |

## Verification
The carry-chained subtracts both consume the incoming C as a borrow and produce a new C in the same cycle. The bench drives 0x6 and 0x7 with C both set and clear, using operands at the borrow boundary (equal operands, and operands differing by one). It then compares the result and the produced C with values worked out from unsigned comparison. The compare opcodes likewise update the flags and hold back the destination write in one cycle, even with set_flags low, and the bench judges both strobes on the same output cycle.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] rn,
  input  logic [W-1:0] op2,
  input  logic [3:0]   nzcv_in,
  input  logic         shift_cout,
  input  logic         set_flags,
  output logic         out_valid,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [3:0]   nzcv_out,
  output logic         flags_we
);
  localparam int MSB = W - 1;

  logic         is_cmp, is_arith, c_in;
  logic [W-1:0] x, y, lres, result;
  logic         cin;
  logic [W:0]   sum;
  logic         ovf, upd;
  logic [3:0]   nf;

  assign c_in     = nzcv_in[1];
  assign is_cmp   = opcode[3:2] == 2'b10;
  assign is_arith = is_cmp ? opcode[1] : (opcode[3:2] == 2'b01 || opcode[3:1] == 3'b001);

  always_comb begin
    x = rn; y = op2; cin = 1'b0;
    case (opcode)
      4'h2, 4'hA: begin x = rn;  y = ~op2; cin = 1'b1; end
      4'h6:       begin x = rn;  y = ~op2; cin = c_in; end
      4'h3:       begin x = op2; y = ~rn;  cin = 1'b1; end
      4'h7:       begin x = op2; y = ~rn;  cin = c_in; end
      4'h5:       begin x = rn;  y = op2;  cin = c_in; end
      default:    begin x = rn;  y = op2;  cin = 1'b0; end
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  always_comb begin
    case (opcode)
      4'h0, 4'h8: lres = rn & op2;
      4'h1, 4'h9: lres = rn ^ op2;
      4'hC:       lres = rn | op2;
      4'hD:       lres = op2;
      4'hE:       lres = rn & ~op2;
      default:    lres = ~op2;
    endcase
  end

  assign result = is_arith ? sum[MSB:0] : lres;
  assign upd    = set_flags | is_cmp;
  assign nf     = {result[MSB], result == '0,
                   is_arith ? sum[W] : shift_cout,
                   is_arith ? ovf : nzcv_in[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      res_we    <= 1'b0;
      nzcv_out  <= 4'h0;
      flags_we  <= 1'b0;
    end else begin
      out_valid <= op_valid;
      res_we    <= op_valid & ~is_cmp;
      flags_we  <= op_valid & upd;
      if (op_valid) begin
        res      <= result;
        nzcv_out <= upd ? nf : nzcv_in;
      end
    end
  end
endmodule

module dp_alu_props #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [3:0]   opcode,
  input logic [W-1:0] rn,
  input logic [W-1:0] op2,
  input logic [3:0]   nzcv_in,
  input logic         shift_cout,
  input logic         set_flags,
  input logic         out_valid,
  input logic [W-1:0] res,
  input logic         res_we,
  input logic [3:0]   nzcv_out,
  input logic         flags_we
);
  a_r4_no_write_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> $past(opcode[3:2]) != 2'b10);
  a_r5_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(op_valid));
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> nzcv_out[2] == (res == '0) && nzcv_out[3] == res[W-1]);
  a_r9_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && ($past(opcode) inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}))
      |-> nzcv_out[0] == $past(nzcv_in[0]) && nzcv_out[1] == $past(shift_cout));
  a_r10_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !flags_we) |-> nzcv_out == $past(nzcv_in));
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !out_valid && !res_we && !flags_we);
endmodule

bind dp_alu dp_alu_props #(.W(W)) u_props (.*);

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [31:0] rn = '0, op2 = '0;
  logic [3:0]  nzcv_in = 4'h0;
  logic        shift_cout = 1'b0, set_flags = 1'b0;
  logic        out_valid, res_we, flags_we;
  logic [31:0] res;
  logic [3:0]  nzcv_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dp_alu u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .rn(rn),
             .op2(op2), .nzcv_in(nzcv_in), .shift_cout(shift_cout), .set_flags(set_flags),
             .out_valid(out_valid), .res(res), .res_we(res_we), .nzcv_out(nzcv_out),
             .flags_we(flags_we));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic sc,
                       output logic [31:0] r, output logic [3:0] nf, output logic arith);
    longint ua, ub, sa, sb, us, ss;
    logic c, v;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    arith = 1'b1; c = f[1]; v = f[0]; us = 0; ss = 0;
    case (op)
      4'h2, 4'hA: begin us = ua - ub; ss = sa - sb; end
      4'h3:       begin us = ub - ua; ss = sb - sa; end
      4'h6:       begin us = ua - ub - (f[1] ? 0 : 1); ss = sa - sb - (f[1] ? 0 : 1); end
      4'h7:       begin us = ub - ua - (f[1] ? 0 : 1); ss = sb - sa - (f[1] ? 0 : 1); end
      4'h4, 4'hB: begin us = ua + ub; ss = sa + sb; end
      4'h5:       begin us = ua + ub + (f[1] ? 1 : 0); ss = sa + sb + (f[1] ? 1 : 0); end
      default:    arith = 1'b0;
    endcase
    if (arith) begin
      r = us[31:0];
      if (op inside {4'h4, 4'h5, 4'hB}) c = us > 64'sh0FFFFFFFF;
      else c = us >= 0;
      v = (ss > 64'sh7FFFFFFF) || (ss < -64'sh80000000);
    end else begin
      case (op)
        4'h0, 4'h8: r = a & b;
        4'h1, 4'h9: r = a ^ b;
        4'hC:       r = a | b;
        4'hD:       r = b;
        4'hE:       r = a & ~b;
        default:    r = ~b;
      endcase
      c = sc;
    end
    nf = {r[31], r == 32'h0, c, v};
  endtask

  task automatic do_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] f, input logic sc, input logic sf);
    logic [31:0] er; logic [3:0] ef; logic ar, cmp;
    model(op, a, b, f, sc, er, ef, ar);
    cmp = op[3:2] == 2'b10;
    @(negedge clk);
    op_valid = 1'b1; opcode = op; rn = a; op2 = b; nzcv_in = f; shift_cout = sc; set_flags = sf;
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " R5 out_valid"}, 32'(out_valid), 32'd1);
    chk({tag, " R1/R2/R3 res"}, res, er);
    chk({tag, " R4 res_we"}, 32'(res_we), 32'(!cmp));
    chk({tag, " R10 flags_we"}, 32'(flags_we), 32'(sf | cmp));
    if (sf | cmp) chk({tag, ar ? " R6/R7/R8 nzcv" : " R6/R9 nzcv"}, 32'(nzcv_out), 32'(ef));
    else          chk({tag, " R10 nzcv hold"}, 32'(nzcv_out), 32'(f));
  endtask

  task automatic t_reset;
    chk("R11 out_valid", 32'(out_valid), 0);
    chk("R11 res_we", 32'(res_we), 0);
    chk("R11 flags_we", 32'(flags_we), 0);
    chk("R11 res", res, 0);
    chk("R11 nzcv", 32'(nzcv_out), 0);
  endtask

  task automatic t_logic;
    do_op("R1 and", 4'h0, 32'hF0F0_1234, 32'hFF00_FF00, 4'h1, 1'b1, 1'b1);
    do_op("R1 xor", 4'h1, 32'hAAAA_5555, 32'hAAAA_5555, 4'h0, 1'b0, 1'b1);
    do_op("R1 orr", 4'hC, 32'h8000_0000, 32'h0000_0001, 4'h0, 1'b1, 1'b1);
    do_op("R1 mov", 4'hD, 32'h1111_1111, 32'h0000_0000, 4'h3, 1'b0, 1'b1);
    do_op("R1 bic", 4'hE, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 4'h0, 1'b0, 1'b1);
    do_op("R9 mvn", 4'hF, 32'h0, 32'h0, 4'h1, 1'b1, 1'b1);
  endtask

  task automatic t_arith;
    do_op("R2 sub borrow", 4'h2, 32'h1, 32'h2, 4'h0, 1'b0, 1'b1);
    do_op("R7 sub eq", 4'h2, 32'h5, 32'h5, 4'h0, 1'b0, 1'b1);
    do_op("R8 sub ovf", 4'h2, 32'h8000_0000, 32'h1, 4'h0, 1'b0, 1'b1);
    do_op("R2 rsb", 4'h3, 32'h10, 32'h3, 4'h0, 1'b0, 1'b1);
    do_op("R8 rsb ovf", 4'h3, 32'h1, 32'h8000_0000, 4'h0, 1'b0, 1'b1);
    do_op("R7 add carry", 4'h4, 32'hFFFF_FFFF, 32'h1, 4'h0, 1'b0, 1'b1);
    do_op("R8 add ovf", 4'h4, 32'h7FFF_FFFF, 32'h1, 4'h0, 1'b0, 1'b1);
  endtask

  task automatic t_carry;
    do_op("R3 adc c1", 4'h5, 32'hFFFF_FFFE, 32'h1, 4'h2, 1'b0, 1'b1);
    do_op("R3 adc c0", 4'h5, 32'hFFFF_FFFE, 32'h1, 4'h0, 1'b0, 1'b1);
    do_op("R3 sbc c1 eq", 4'h6, 32'h7, 32'h7, 4'h2, 1'b0, 1'b1);
    do_op("R3 sbc c0 eq", 4'h6, 32'h7, 32'h7, 4'h0, 1'b0, 1'b1);
    do_op("R3 sbc c0 diff1", 4'h6, 32'h8, 32'h7, 4'h0, 1'b0, 1'b1);
    do_op("R3 rsc c1", 4'h7, 32'h7, 32'h7, 4'h2, 1'b0, 1'b1);
    do_op("R3 rsc c0", 4'h7, 32'h7, 32'h8, 4'h0, 1'b0, 1'b1);
    do_op("R3 rsc c0 borrow", 4'h7, 32'h7, 32'h7, 4'h0, 1'b0, 1'b1);
  endtask

  task automatic t_compare;
    do_op("R4 tst", 4'h8, 32'h0F, 32'hF0, 4'h1, 1'b1, 1'b0);
    do_op("R4 teq", 4'h9, 32'h8000_0000, 32'h0, 4'h0, 1'b0, 1'b0);
    do_op("R4 cmp", 4'hA, 32'h3, 32'h3, 4'h0, 1'b0, 1'b0);
    do_op("R4 cmn", 4'hB, 32'h8000_0000, 32'h8000_0000, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_noflags;
    do_op("R10 add nosf", 4'h4, 32'hFFFF_FFFF, 32'h1, 4'h9, 1'b0, 1'b0);
    do_op("R10 and nosf", 4'h0, 32'h0, 32'h0, 4'h6, 1'b1, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_valid = 1'b0; opcode = 4'h4;
    @(negedge clk);
    chk("R12 out_valid", 32'(out_valid), 0);
    chk("R12 res_we", 32'(res_we), 0);
    chk("R12 flags_we", 32'(flags_we), 0);
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 16; op++) begin
      do_op("R1/R2 sweep a", 4'(op), 32'h1234_5678, 32'h8765_4321, 4'h2, 1'b1, 1'b1);
      do_op("R1/R2 sweep b", 4'(op), 32'hFFFF_FFFF, 32'h0000_0000, 4'h5, 1'b0, 1'b1);
    end
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_logic();
    t_arith();
    t_carry();
    t_compare();
    t_noflags();
    t_sweep();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule